// File: doc/BRIEF.md
# Machine-Cycle Reset Sequencer

This block produces the internal reset for a small processor core whose machine cycle has four clock phases, C1 to C4. It has three sources of reset. The first is an asynchronous power-on indication. The second is an external reset pin. The third is a request from a watchdog counter that sits outside the block. The block also drives a phase indicator, so that the core and the block agree on where each machine cycle starts.

The external pin passes through a two-stage synchronizer and is examined only at the C4 edge of each machine cycle. Two high samples in a row are needed before reset is asserted. Once the pin is released, reset continues for two more full machine cycles. A watchdog request gives a reset of exactly two machine cycles, and the phase restarts at C1. Two sticky flags record a power-on or a watchdog cause, and software can clear each flag with a strobe. An external reset sets neither flag, so software reads both flags clear as an external cause.

Top module: `mc_reset_ctrl`

## Requirements
- R1: `phase_o` advances by one every clock (0=C1, 1=C2, 2=C3, 3=C4, then back to 0). It is forced to 0 while power-on reset is active and on the clock that starts a watchdog reset. `sys_rst_o` only falls at the end of a C4, so the first clock out of reset is always phase 0.
- R2: `ext_rst_i` passes through a two-flop synchronizer and is sampled only on the clock edge that ends C4. A pulse that is not at the synchronizer output at that edge is ignored. For example, a two-clock pulse driven over C3 and C4 is never seen, while the same pulse driven over C1 and C2 is sampled.
- R3: `sys_rst_o` rises only after two consecutive C4 samples are high. A single high sample causes no reset.
- R4: `sys_rst_o` stays high for as long as the C4 samples stay high.
- R5: After the first low C4 sample, `sys_rst_o` stays high for two more machine cycles. If the pin is dropped at the start of a C1, reset therefore stays high for 12 more clocks, counting that clock.
- R6: While `sys_rst_o` is low, a one-clock `wdt_req_i` raises `sys_rst_o` on the next clock for exactly 8 clocks, and the phase restarts at C1. While `sys_rst_o` is high, `wdt_req_i` is ignored.
- R7: While `por_i` is high, `sys_rst_o` is 1, `phase_o` is 0, `por_flag_o` is 1 and `wdt_flag_o` is 0. After `por_i` falls, `sys_rst_o` stays high for 9 clocks: one clock of synchronizer release, then two machine cycles.
- R8: `por_flag_o` is set by power-on reset and cleared one clock after a `clr_por_flag_i` strobe. External and watchdog resets do not change it.
- R9: `wdt_flag_o` is set by a watchdog reset. It is cleared by power-on reset or one clock after a `clr_wdt_flag_i` strobe, and it is kept through an external reset.
- R10: An external reset sets neither flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one phase per cycle |
| por_i | input | 1 | Power-on indication, active high, asynchronous assert |
| ext_rst_i | input | 1 | External reset pin, active high, asynchronous |
| wdt_req_i | input | 1 | Watchdog reset request, synchronous pulse |
| clr_por_flag_i | input | 1 | Strobe that clears the power-on flag |
| clr_wdt_flag_i | input | 1 | Strobe that clears the watchdog flag |
| sys_rst_o | output | 1 | Internal reset, active high |
| por_flag_o | output | 1 | Sticky power-on cause flag |
| wdt_flag_o | output | 1 | Sticky watchdog cause flag |
| phase_o | output | 2 | Machine phase, 0 = C1 to 3 = C4 |

## Verification
The pin is driven with a held level of several lengths, with a single-cycle high, and with two-clock pulses placed either over C1 and C2 or over C3 and C4. This separates sampling at C4 from level-sensing and from edge-sensing, and separates the two-sample rule from a one-sample rule. The length of each reset is counted clock by clock after the pin release, after a watchdog request and after power-on, together with the phase on the first clock out of reset. These counts show whether the stretch is measured in machine cycles and whether release is tied to the C4 boundary. A watchdog request issued inside an external reset, and each flag checked around every type of reset, show which sources set or keep each flag.

// File: rtl/mc_reset_pkg.sv
package mc_reset_pkg;
  typedef enum logic [1:0] {
    PH_C1 = 2'd0,
    PH_C2 = 2'd1,
    PH_C3 = 2'd2,
    PH_C4 = 2'd3
  } phase_t;
endpackage

// File: rtl/mcr_sync.sv
// Bit synchronizer. With SET_MODE=1 the chain is set asynchronously by set_i
// and drains to d_i (reset-style release); otherwise set_i clears it synchronously.
module mcr_sync #(
  parameter int STAGES   = 2,
  parameter bit SET_MODE = 1'b0
) (
  input  logic clk,
  input  logic set_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (SET_MODE) begin : g_async_set
      always_ff @(posedge clk or posedge set_i) begin
        if (set_i) chain_q <= '1;
        else       chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end else begin : g_sync_clr
      always_ff @(posedge clk) begin
        if (set_i) chain_q <= '0;
        else       chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/mcr_phase.sv
module mcr_phase
  import mc_reset_pkg::*;
(
  input  logic   clk,
  input  logic   rst_i,
  input  logic   restart_i,
  output phase_t phase_o,
  output logic   c4_o
);
  phase_t phase_q;

  always_ff @(posedge clk) begin
    if (rst_i || restart_i) phase_q <= PH_C1;
    else                    phase_q <= phase_t'(phase_q + 2'd1);
  end

  assign phase_o = phase_q;
  assign c4_o    = (phase_q == PH_C4);

  // R1: free-running step unless restarted
  a_r1_phase_step: assert property (@(posedge clk) disable iff (rst_i)
    !restart_i |=> (2'(phase_q) == 2'($past(phase_q) + 2'd1)));
endmodule

// File: rtl/mcr_pin_qual.sv
// Samples the synchronized pin at C4 and qualifies a run of high samples.
module mcr_pin_qual #(
  parameter int HI_SAMPLES = 2
) (
  input  logic clk,
  input  logic rst_i,
  input  logic c4_i,
  input  logic pin_i,
  output logic load_o,
  output logic ext_o
);
  localparam int CW = $clog2(HI_SAMPLES + 1);
  localparam logic [CW-1:0] NEED = CW'(HI_SAMPLES - 1);

  logic [CW-1:0] run_q;
  logic          ext_q;
  logic          qual;

  assign qual = c4_i && pin_i && (run_q >= NEED);

  always_ff @(posedge clk) begin
    if (rst_i) begin
      run_q <= '0;
      ext_q <= 1'b0;
    end else if (c4_i) begin
      ext_q <= qual;
      if (!pin_i)              run_q <= '0;
      else if (run_q < NEED)   run_q <= run_q + 1'b1;
    end
  end

  assign load_o = qual;
  assign ext_o  = ext_q;

  // R2: pin state is only taken at C4
  a_r2_only_at_c4: assert property (@(posedge clk) disable iff (rst_i)
    !c4_i |=> $stable(ext_o));
  // R5: a low sample ends the pin-driven phase
  a_r5_low_sample_drops: assert property (@(posedge clk) disable iff (rst_i)
    (c4_i && !pin_i) |=> !ext_o);
endmodule

// File: rtl/mcr_hold.sv
// Counts the reset stretch in machine cycles and starts watchdog resets.
module mcr_hold #(
  parameter int HOLD_MC = 2
) (
  input  logic clk,
  input  logic rst_i,
  input  logic c4_i,
  input  logic load_i,
  input  logic ext_i,
  input  logic wdt_req_i,
  output logic sys_rst_o,
  output logic wdt_start_o
);
  localparam int HW = $clog2(HOLD_MC + 1);
  localparam logic [HW-1:0] HOLD_V = HW'(HOLD_MC);

  logic [HW-1:0] hold_q, hold_d;
  logic          rst_q;
  logic          wdt_start;

  assign wdt_start = wdt_req_i && !rst_q;

  always_comb begin
    hold_d = hold_q;
    if (load_i || wdt_start)                   hold_d = HOLD_V;
    else if (c4_i && !ext_i && hold_q != '0)   hold_d = hold_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst_i) begin
      hold_q <= HOLD_V;
      rst_q  <= 1'b1;
    end else begin
      hold_q <= hold_d;
      rst_q  <= (hold_d != '0);
    end
  end

  assign sys_rst_o   = rst_q;
  assign wdt_start_o = wdt_start;

  // R1: release only on the C4 boundary
  a_r1_release_at_c4: assert property (@(posedge clk) disable iff (rst_i)
    $fell(sys_rst_o) |-> $past(c4_i));
  // R4: an active pin always keeps reset high
  a_r4_ext_holds: assert property (@(posedge clk) disable iff (rst_i)
    ext_i |-> sys_rst_o);
  // R6: a watchdog start raises reset on the next clock
  a_r6_wdt_asserts: assert property (@(posedge clk) disable iff (rst_i)
    wdt_start |=> sys_rst_o);
endmodule

// File: rtl/mc_reset_ctrl.sv
module mc_reset_ctrl
  import mc_reset_pkg::*;
#(
  parameter int POR_SYNC     = 2,
  parameter int PIN_SYNC     = 2,
  parameter int QUAL_SAMPLES = 2,
  parameter int HOLD_MC      = 2
) (
  input  logic       clk,
  input  logic       por_i,
  input  logic       ext_rst_i,
  input  logic       wdt_req_i,
  input  logic       clr_por_flag_i,
  input  logic       clr_wdt_flag_i,
  output logic       sys_rst_o,
  output logic       por_flag_o,
  output logic       wdt_flag_o,
  output logic [1:0] phase_o
);
  logic   por_rst;
  logic   pin_s;
  phase_t phase;
  logic   c4;
  logic   load, ext_act;
  logic   wdt_start;
  logic   sys_rst;
  logic   por_flag_q, wdt_flag_q;

  mcr_sync #(.STAGES(POR_SYNC), .SET_MODE(1'b1)) u_por_sync (
    .clk(clk), .set_i(por_i), .d_i(1'b0), .q_o(por_rst)
  );

  mcr_sync #(.STAGES(PIN_SYNC), .SET_MODE(1'b0)) u_pin_sync (
    .clk(clk), .set_i(por_rst), .d_i(ext_rst_i), .q_o(pin_s)
  );

  mcr_phase u_phase (
    .clk(clk), .rst_i(por_rst), .restart_i(wdt_start),
    .phase_o(phase), .c4_o(c4)
  );

  mcr_pin_qual #(.HI_SAMPLES(QUAL_SAMPLES)) u_qual (
    .clk(clk), .rst_i(por_rst), .c4_i(c4), .pin_i(pin_s),
    .load_o(load), .ext_o(ext_act)
  );

  mcr_hold #(.HOLD_MC(HOLD_MC)) u_hold (
    .clk(clk), .rst_i(por_rst), .c4_i(c4), .load_i(load), .ext_i(ext_act),
    .wdt_req_i(wdt_req_i), .sys_rst_o(sys_rst), .wdt_start_o(wdt_start)
  );

  always_ff @(posedge clk) begin
    if (por_rst) begin
      por_flag_q <= 1'b1;
      wdt_flag_q <= 1'b0;
    end else begin
      if (clr_por_flag_i) por_flag_q <= 1'b0;
      if (wdt_start)           wdt_flag_q <= 1'b1;
      else if (clr_wdt_flag_i) wdt_flag_q <= 1'b0;
    end
  end

  assign sys_rst_o  = sys_rst;
  assign por_flag_o = por_flag_q;
  assign wdt_flag_o = wdt_flag_q;
  assign phase_o    = phase;

  // R6: watchdog start restarts the phase and records the cause
  a_r6_wdt_restart: assert property (@(posedge clk) disable iff (por_rst)
    wdt_start |=> (sys_rst_o && wdt_flag_o && phase_o == 2'd0));
  // R8: power-on flag moves only on its clear strobe outside power-on
  a_r8_por_flag_sticky: assert property (@(posedge clk) disable iff (por_rst)
    !clr_por_flag_i |=> $stable(por_flag_o));
  // R9: watchdog flag moves only on a watchdog start or its clear strobe
  a_r9_wdt_flag_sticky: assert property (@(posedge clk) disable iff (por_rst)
    (!wdt_start && !clr_wdt_flag_i) |=> $stable(wdt_flag_o));
endmodule

// File: tb/mc_reset_ctrl_test.sv
module mc_reset_ctrl_test;
  logic       clk = 1'b0;
  logic       por_i = 1'b1;
  logic       ext_rst_i = 1'b0;
  logic       wdt_req_i = 1'b0;
  logic       clr_por_flag_i = 1'b0;
  logic       clr_wdt_flag_i = 1'b0;
  logic       sys_rst_o, por_flag_o, wdt_flag_o;
  logic [1:0] phase_o;

  int checks = 0;
  int bad = 0;

  always #5 clk = ~clk;

  mc_reset_ctrl uut (
    .clk(clk), .por_i(por_i), .ext_rst_i(ext_rst_i), .wdt_req_i(wdt_req_i),
    .clr_por_flag_i(clr_por_flag_i), .clr_wdt_flag_i(clr_wdt_flag_i),
    .sys_rst_o(sys_rst_o), .por_flag_o(por_flag_o), .wdt_flag_o(wdt_flag_o),
    .phase_o(phase_o)
  );

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_phase(input int p);
    @(negedge clk);
    while (phase_o != 2'(p)) @(negedge clk);
  endtask

  task automatic count_high(output int n);
    n = 0;
    while (sys_rst_o && n < 200) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_por;
    int n;
    por_i = 1'b1;
    tick(3);
    check_eq("R7 sys_rst in por", int'(sys_rst_o), 1);
    check_eq("R7 phase in por", int'(phase_o), 0);
    check_eq("R7 por_flag in por", int'(por_flag_o), 1);
    check_eq("R9 wdt_flag cleared by por", int'(wdt_flag_o), 0);
    por_i = 1'b0;
    tick(1);
    count_high(n);
    check_eq("R7 por release length", n, 9);
    check_eq("R1 phase after por release", int'(phase_o), 0);
  endtask

  task automatic t_ext(input int hold_mc, input bit poke_wdt);
    int n, lows;
    wait_phase(0);
    ext_rst_i = 1'b1;
    tick(4);
    check_eq("R3 one sample no reset", int'(sys_rst_o), 0);
    tick(4);
    check_eq("R3 two samples reset", int'(sys_rst_o), 1);
    lows = 0;
    for (int i = 0; i < hold_mc * 4; i++) begin
      if (poke_wdt && i == 0) wdt_req_i = 1'b1;
      @(negedge clk);
      wdt_req_i = 1'b0;
      if (!sys_rst_o) lows++;
    end
    check_eq("R4 held while pin high", lows, 0);
    ext_rst_i = 1'b0;
    count_high(n);
    check_eq("R5 stretch after release", n, 12);
    check_eq("R1 phase after ext release", int'(phase_o), 0);
  endtask

  task automatic t_single;
    int highs = 0;
    wait_phase(0);
    ext_rst_i = 1'b1;
    tick(4);
    ext_rst_i = 1'b0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (sys_rst_o) highs++;
    end
    check_eq("R3 single high sample ignored", highs, 0);
  endtask

  task automatic t_offwindow;
    int highs = 0;
    for (int k = 0; k < 3; k++) begin
      wait_phase(2);
      ext_rst_i = 1'b1;
      wait_phase(0);
      ext_rst_i = 1'b0;
      if (sys_rst_o) highs++;
    end
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (sys_rst_o) highs++;
    end
    check_eq("R2 C3-C4 pulses ignored", highs, 0);
  endtask

  task automatic t_inwindow;
    int highs = 0;
    int n;
    for (int k = 0; k < 2; k++) begin
      wait_phase(0);
      ext_rst_i = 1'b1;
      tick(2);
      ext_rst_i = 1'b0;
    end
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (sys_rst_o) highs++;
    end
    check_eq("R2 C1-C2 pulses sampled", int'(highs > 0), 1);
    count_high(n);
    check_eq("R1 phase after pulse reset", int'(phase_o), 0);
  endtask

  task automatic t_wdt;
    int n;
    wait_phase(1);
    wdt_req_i = 1'b1;
    @(negedge clk);
    wdt_req_i = 1'b0;
    check_eq("R6 phase restart", int'(phase_o), 0);
    check_eq("R9 wdt_flag set", int'(wdt_flag_o), 1);
    count_high(n);
    check_eq("R6 wdt reset length", n, 8);
    check_eq("R1 phase after wdt release", int'(phase_o), 0);
  endtask

  task automatic t_clr(input bit which_wdt);
    if (which_wdt) clr_wdt_flag_i = 1'b1;
    else           clr_por_flag_i = 1'b1;
    @(negedge clk);
    clr_wdt_flag_i = 1'b0;
    clr_por_flag_i = 1'b0;
    if (which_wdt) check_eq("R9 wdt_flag cleared by strobe", int'(wdt_flag_o), 0);
    else           check_eq("R8 por_flag cleared by strobe", int'(por_flag_o), 0);
  endtask

  initial begin
    t_por();
    t_ext(2, 1'b0);
    check_eq("R8 por_flag kept through ext", int'(por_flag_o), 1);
    check_eq("R10 ext sets no wdt_flag", int'(wdt_flag_o), 0);
    t_clr(1'b0);
    t_ext(1, 1'b1);
    check_eq("R10 ext sets no por_flag", int'(por_flag_o), 0);
    check_eq("R6 wdt ignored in reset", int'(wdt_flag_o), 0);
    t_single();
    t_offwindow();
    t_inwindow();
    check_eq("R10 pulses set no flag", int'(por_flag_o) + int'(wdt_flag_o), 0);
    t_wdt();
    check_eq("R8 por_flag untouched by wdt", int'(por_flag_o), 0);
    t_ext(1, 1'b0);
    check_eq("R9 wdt_flag kept through ext", int'(wdt_flag_o), 1);
    t_clr(1'b1);
    t_wdt();
    t_por();
    check_eq("R8 por_flag set by por", int'(por_flag_o), 1);
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    bad++;
    $display("FAIL timeout R1-watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule